// File: doc/BRIEF.md
# Multi-Bank Programmable Clock Divider

This block turns one fast source clock into three banks of divided clocks and one feedback clock. Each bank has its own divide ratio, picked by a small select field. A shared pre-scaler sits ahead of all four dividers and lets every bank count either every source cycle or every second one. All outputs are registered in the source clock domain. Every divider starts on the same source edge after reset, so the banks stay phase-aligned and their rising edges meet at every common multiple of their periods.

The upper half of bank C can be flipped to run 180 degrees out of phase with its lower half. A serial stop register is loaded through its own clock and data pins, and it can park any bank output at logic low. A stop or a release always waits for a point where it cannot shorten a pulse. The feedback output cannot be stopped. It always runs, so an external loop stays closed.

Top module: `clkdiv_banks`

## Requirements
- R1: With `pre_div1`=1 the dividers advance on every source rising edge. With `pre_div1`=0 they advance on every second edge. In both cases the first advance is on the first rising edge after reset is released.
- R2: `sel_a` picks the bank A ratio: 0 gives 4, 1 gives 6, 2 gives 8, 3 gives 12.
- R3: `sel_b` picks the bank B ratio: 0 gives 4, 1 gives 6, 2 gives 8, 3 gives 10.
- R4: `sel_c` picks the bank C ratio: 0 gives 2, 1 gives 4, 2 gives 6, 3 gives 8.
- R5: `sel_fb` picks the feedback ratio: 0 gives 4, 1 gives 6, 2 gives 8, 3 gives 10, 4 gives 12, 5 gives 16, and 6 or 7 give 20.
- R6: A divide-by-N output is high for N/2 divider advances and low for the next N/2. Every output first goes high on the first advance after reset, so all outputs rise together at that point.
- R7: When `inv_c` is 1, the upper half of bank C (`q_c[3:2]`) is the complement of the running phase of the lower half. When `inv_c` is 0, the upper half equals the lower half. `inv_c` is meant to change only under reset.
- R8: Reset is asynchronous and active high. While `rst` is 1, every output is 0, and the dividers, the pre-scaler and the stop mask are cleared.
- R9: The stop word is 12 bits, sent MSB first on rising `stop_clk` edges. Bit i stops `q_a[i]`, bit 4+i stops `q_b[i]`, and bit 8+i stops `q_c[i]`, where a 1 means stopped. A word takes effect only after its twelfth bit. A partly shifted word changes nothing.
- R10: A stopped output is held at 0. A stop begins only during the output's low phase, and a release takes effect only at a rising phase boundary. Every high pulse is therefore the full N/2 advances long.
- R11: `q_fb` is never affected by the stop word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Fast source clock |
| rst | input | 1 | Asynchronous active-high reset |
| pre_div1 | input | 1 | 1: count every edge, 0: every second edge |
| sel_a | input | 2 | Bank A ratio select |
| sel_b | input | 2 | Bank B ratio select |
| sel_c | input | 2 | Bank C ratio select |
| sel_fb | input | 3 | Feedback ratio select |
| inv_c | input | 1 | Invert upper half of bank C |
| stop_clk | input | 1 | Serial stop-word clock |
| stop_dat | input | 1 | Serial stop-word data, MSB first |
| q_a | output | NA (4) | Bank A clocks |
| q_b | output | NB (4) | Bank B clocks |
| q_c | output | NC (4) | Bank C clocks |
| q_fb | output | 1 | Feedback clock |

## Verification
Each divided output is registered on the same edge that advances its divider. The value after the k-th rising edge following reset release is therefore a closed-form function of k, the ratio and the pre-scale setting. The bench compares against that function at the falling edge after each rising edge. A stop word reaches the outputs through a three-flop crossing and then waits for the next low phase, which can be up to one period. The bench therefore allows a fixed settle window after the twelfth stop bit before it demands exact masking. During that window it still requires that no output is high when its free-running phase is low and that every high pulse has its full width. Reset is checked one nanosecond after it is raised, because it clears the outputs without waiting for an edge.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
   localparam int DIV_W = 5;   // wide enough for the largest ratio (20)

   typedef enum int {DV_A = 0, DV_B = 1, DV_C = 2, DV_FB = 3} div_idx_e;
   localparam int NUM_DIV = 4;

   function automatic logic [DIV_W-1:0] ratio_a(input logic [1:0] s);
      case (s)
         2'd0:    return DIV_W'(4);
         2'd1:    return DIV_W'(6);
         2'd2:    return DIV_W'(8);
         default: return DIV_W'(12);
      endcase
   endfunction

   function automatic logic [DIV_W-1:0] ratio_b(input logic [1:0] s);
      return DIV_W'(4 + 2 * int'(s));
   endfunction

   function automatic logic [DIV_W-1:0] ratio_c(input logic [1:0] s);
      return DIV_W'(2 + 2 * int'(s));
   endfunction

   function automatic logic [DIV_W-1:0] ratio_fb(input logic [2:0] s);
      case (s)
         3'd0:    return DIV_W'(4);
         3'd1:    return DIV_W'(6);
         3'd2:    return DIV_W'(8);
         3'd3:    return DIV_W'(10);
         3'd4:    return DIV_W'(12);
         3'd5:    return DIV_W'(16);
         default: return DIV_W'(20);
      endcase
   endfunction
endpackage

// File: rtl/clkdiv_prescale.sv
`timescale 1ns/1ps
module clkdiv_prescale (
   input  logic clk,
   input  logic rst,
   input  logic div1,
   output logic tick
);
   logic skip;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) skip <= 1'b0;
      else     skip <= ~skip;
   end

   assign tick = div1 | ~skip;

   // R1: in divide-by-2 mode an advance is always followed by an idle cycle
   assert_alternate_tick_R1: assert property (@(posedge clk) disable iff (rst)
      (!div1 && tick) |=> (!tick || div1));
endmodule

// File: rtl/clkdiv_counter.sv
`timescale 1ns/1ps
module clkdiv_counter #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         tick,
   input  logic [W-1:0] ratio,
   output logic         phase,
   output logic         phase_nx
);
   logic [W-1:0] cnt, cnt_nx, half;
   logic         started;

   assign half = ratio >> 1;

   always_comb begin
      if (!started)                cnt_nx = '0;
      else if (cnt >= ratio - 1'b1) cnt_nx = '0;
      else                         cnt_nx = cnt + 1'b1;
      phase_nx = (cnt_nx < half);
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         cnt     <= '0;
         started <= 1'b0;
         phase   <= 1'b0;
      end else if (tick) begin
         cnt     <= cnt_nx;
         started <= 1'b1;
         phase   <= phase_nx;
      end
   end

   // R6: every high phase begins at the start of a period
   assert_period_start_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(phase) |-> (cnt == '0));
endmodule

// File: rtl/clkdiv_gate.sv
`timescale 1ns/1ps
module clkdiv_gate (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic invert,
   input  logic stop_req,
   input  logic phase,
   input  logic phase_nx,
   output logic out
);
   logic hold, p_cur, p_nx;

   assign p_cur = phase ^ invert;
   assign p_nx  = phase_nx ^ invert;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         hold <= 1'b0;
         out  <= 1'b0;
      end else if (tick) begin
         if (!p_cur) begin
            hold <= stop_req;
            out  <= p_nx & ~stop_req;
         end else begin
            out  <= p_nx & ~hold;
         end
      end
   end

   // R10: a stopped output is low
   assert_stopped_low_R10: assert property (@(posedge clk) disable iff (rst)
      hold |-> !out);
   // R10: the output rises only together with its phase
   assert_rise_on_phase_R10: assert property (@(posedge clk) disable iff (rst)
      $rose(out) |-> $rose(p_cur));
   // R10: the output falls only together with its phase
   assert_fall_on_phase_R10: assert property (@(posedge clk) disable iff (rst)
      $fell(out) |-> $fell(p_cur));
endmodule

// File: rtl/clkdiv_stop_shift.sv
`timescale 1ns/1ps
module clkdiv_stop_shift #(
   parameter int N = 12
) (
   input  logic         sclk,
   input  logic         rst,
   input  logic         sdat,
   output logic [N-1:0] mask,
   output logic         frame_tgl
);
   localparam int CW = $clog2(N + 1);

   logic [N-1:0]  sh;
   logic [CW-1:0] bitcnt;

   always_ff @(posedge sclk or posedge rst) begin
      if (rst) begin
         sh        <= '0;
         bitcnt    <= '0;
         mask      <= '0;
         frame_tgl <= 1'b0;
      end else if (bitcnt == CW'(N - 1)) begin
         mask      <= {sh[N-2:0], sdat};
         sh        <= '0;
         bitcnt    <= '0;
         frame_tgl <= ~frame_tgl;
      end else begin
         sh        <= {sh[N-2:0], sdat};
         bitcnt    <= bitcnt + 1'b1;
      end
   end

   // R9: the bit counter never passes the word length
   assert_bitcount_R9: assert property (@(posedge sclk) disable iff (rst)
      bitcnt < CW'(N));
endmodule

// File: rtl/clkdiv_banks.sv
`timescale 1ns/1ps
module clkdiv_banks
   import clkdiv_pkg::*;
#(
   parameter int NA = 4,
   parameter int NB = 4,
   parameter int NC = 4
) (
   input  logic          clk_src,
   input  logic          rst,
   input  logic          pre_div1,
   input  logic [1:0]    sel_a,
   input  logic [1:0]    sel_b,
   input  logic [1:0]    sel_c,
   input  logic [2:0]    sel_fb,
   input  logic          inv_c,
   input  logic          stop_clk,
   input  logic          stop_dat,
   output logic [NA-1:0] q_a,
   output logic [NB-1:0] q_b,
   output logic [NC-1:0] q_c,
   output logic          q_fb
);
   localparam int NOUT   = NA + NB + NC;
   localparam int BASE_B = NA;
   localparam int BASE_C = NA + NB;

   if (NC < 2 || (NC % 2) != 0) begin : g_bad_nc
      $error("NC must be even and at least 2");
   end
   if (NOUT < 2) begin : g_bad_nout
      $error("at least two stoppable outputs are required");
   end
   if (DIV_W < 5) begin : g_bad_w
      $error("DIV_W too narrow for ratio 20");
   end

   logic tick;
   clkdiv_prescale u_pre (
      .clk(clk_src), .rst(rst), .div1(pre_div1), .tick(tick)
   );

   logic [DIV_W-1:0] ratio    [NUM_DIV];
   logic             ph       [NUM_DIV];
   logic             ph_nx    [NUM_DIV];

   assign ratio[DV_A]  = ratio_a(sel_a);
   assign ratio[DV_B]  = ratio_b(sel_b);
   assign ratio[DV_C]  = ratio_c(sel_c);
   assign ratio[DV_FB] = ratio_fb(sel_fb);

   for (genvar d = 0; d < NUM_DIV; d++) begin : g_div
      clkdiv_counter #(.W(DIV_W)) u_cnt (
         .clk(clk_src), .rst(rst), .tick(tick), .ratio(ratio[d]),
         .phase(ph[d]), .phase_nx(ph_nx[d])
      );
   end

   // stop word: serial domain, then toggle-handshake into source domain
   logic [NOUT-1:0] mask_stop, mask_src;
   logic            frame_tgl;
   logic [2:0]      tsync;

   clkdiv_stop_shift #(.N(NOUT)) u_stop (
      .sclk(stop_clk), .rst(rst), .sdat(stop_dat),
      .mask(mask_stop), .frame_tgl(frame_tgl)
   );

   always_ff @(posedge clk_src or posedge rst) begin
      if (rst) begin
         tsync    <= '0;
         mask_src <= '0;
      end else begin
         tsync <= {tsync[1:0], frame_tgl};
         if (tsync[2] ^ tsync[1]) mask_src <= mask_stop;
      end
   end

   for (genvar i = 0; i < NA; i++) begin : g_a
      clkdiv_gate u_g (
         .clk(clk_src), .rst(rst), .tick(tick), .invert(1'b0),
         .stop_req(mask_src[i]), .phase(ph[DV_A]), .phase_nx(ph_nx[DV_A]),
         .out(q_a[i])
      );
   end

   for (genvar i = 0; i < NB; i++) begin : g_b
      clkdiv_gate u_g (
         .clk(clk_src), .rst(rst), .tick(tick), .invert(1'b0),
         .stop_req(mask_src[BASE_B+i]), .phase(ph[DV_B]), .phase_nx(ph_nx[DV_B]),
         .out(q_b[i])
      );
   end

   for (genvar i = 0; i < NC; i++) begin : g_c
      logic pol;
      if (i >= NC / 2) begin : g_shift
         assign pol = inv_c;
      end else begin : g_plain
         assign pol = 1'b0;
      end
      clkdiv_gate u_g (
         .clk(clk_src), .rst(rst), .tick(tick), .invert(pol),
         .stop_req(mask_src[BASE_C+i]), .phase(ph[DV_C]), .phase_nx(ph_nx[DV_C]),
         .out(q_c[i])
      );
   end

   clkdiv_gate u_fb (
      .clk(clk_src), .rst(rst), .tick(tick), .invert(1'b0),
      .stop_req(1'b0), .phase(ph[DV_FB]), .phase_nx(ph_nx[DV_FB]),
      .out(q_fb)
   );
endmodule

// File: tb/test_clkdiv_banks.sv
`timescale 1ns/1ps
module test_clkdiv_banks;
   logic       clk_src = 1'b0;
   logic       rst = 1'b1;
   logic       pre_div1 = 1'b1;
   logic [1:0] sel_a = '0, sel_b = '0, sel_c = '0;
   logic [2:0] sel_fb = '0;
   logic       inv_c = 1'b1;
   logic       stop_clk = 1'b0, stop_dat = 1'b0;
   logic [3:0] q_a, q_b, q_c;
   logic       q_fb;

   always #2.5 clk_src = ~clk_src;   // 200 MHz

   clkdiv_banks i_clkdiv_banks (
      .clk_src(clk_src), .rst(rst), .pre_div1(pre_div1),
      .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .sel_fb(sel_fb),
      .inv_c(inv_c), .stop_clk(stop_clk), .stop_dat(stop_dat),
      .q_a(q_a), .q_b(q_b), .q_c(q_c), .q_fb(q_fb)
   );

   int n_chk = 0, n_fail = 0;
   int k = 0;                 // rising edges since reset release
   bit done = 0;

   always @(posedge clk_src) begin
      if (rst) k = 0;
      else     k = k + 1;
   end

   // {pre_div1, sel_a, sel_b, sel_c, sel_fb, inv_c}
   localparam logic [10:0] VEC [8] = '{
      {1'b1, 2'd0, 2'd0, 2'd0, 3'd0, 1'b1},
      {1'b1, 2'd1, 2'd1, 2'd1, 3'd1, 1'b0},
      {1'b1, 2'd2, 2'd2, 2'd2, 3'd2, 1'b1},
      {1'b1, 2'd3, 2'd3, 2'd3, 3'd3, 1'b0},
      {1'b0, 2'd3, 2'd2, 2'd1, 3'd4, 1'b1},
      {1'b0, 2'd0, 2'd3, 2'd3, 3'd5, 1'b0},
      {1'b1, 2'd1, 2'd0, 2'd2, 3'd6, 1'b1},
      {1'b0, 2'd2, 2'd1, 2'd0, 3'd7, 1'b0}
   };

   function automatic int div_a(input int s);
      case (s) 0: return 4; 1: return 6; 2: return 8; default: return 12; endcase
   endfunction
   function automatic int div_b(input int s);
      case (s) 0: return 4; 1: return 6; 2: return 8; default: return 10; endcase
   endfunction
   function automatic int div_c(input int s);
      case (s) 0: return 2; 1: return 4; 2: return 6; default: return 8; endcase
   endfunction
   function automatic int div_fb(input int s);
      case (s)
         0: return 4; 1: return 6; 2: return 8; 3: return 10;
         4: return 12; 5: return 16; default: return 20;
      endcase
   endfunction

   function automatic bit phase_at(input int n, input int kk, input bit d1);
      int t;
      if (kk < 1) return 1'b0;
      t = d1 ? kk : (kk + 1) / 2;
      return ((t - 1) % n) < (n / 2);
   endfunction

   // expected {fb, c[3:0], b[3:0], a[3:0]} with no stops
   function automatic logic [12:0] expect_vec(input int kk);
      logic [12:0] e;
      bit pa, pb, pc, pf;
      pa = phase_at(div_a(int'(sel_a)), kk, pre_div1);
      pb = phase_at(div_b(int'(sel_b)), kk, pre_div1);
      pc = phase_at(div_c(int'(sel_c)), kk, pre_div1);
      pf = phase_at(div_fb(int'(sel_fb)), kk, pre_div1);
      e[3:0]  = {4{pa}};
      e[7:4]  = {4{pb}};
      e[9:8]  = {2{pc}};
      e[11:10] = (kk < 1) ? 2'b00 : {2{pc ^ inv_c}};
      e[12]   = pf;
      return e;
   endfunction

   function automatic logic [12:0] act_vec();
      return {q_fb, q_c, q_b, q_a};
   endfunction

   task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s k=%0d actual=%b expected=%b", req, k, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic reset_with(input logic [10:0] v);
      @(negedge clk_src);
      rst = 1'b1;
      {pre_div1, sel_a, sel_b, sel_c, sel_fb, inv_c} = v;
      repeat (2) @(negedge clk_src);
      check("R8 reset outputs", act_vec(), 13'd0);
      rst = 1'b0;
   endtask

   // ---------- stop-phase monitor ----------
   bit          mon_on = 0, exact_on = 0;
   logic [11:0] mask_exp = '0;
   int          run [13];

   function automatic int hi_width(input int b);
      int n;
      if (b < 4)       n = div_a(int'(sel_a));
      else if (b < 8)  n = div_b(int'(sel_b));
      else if (b < 12) n = div_c(int'(sel_c));
      else             n = div_fb(int'(sel_fb));
      return (n / 2) * (pre_div1 ? 1 : 2);
   endfunction

   always @(negedge clk_src) begin
      if (mon_on) begin
         logic [12:0] e, a;
         e = expect_vec(k);
         a = act_vec();
         // R10: never high while the free-running phase is low
         check("R10 no extra high", a & ~e, 13'd0);
         for (int b = 0; b < 13; b++) begin
            if (a[b]) run[b]++;
            else if (run[b] > 0) begin
               n_chk++;
               if (run[b] != hi_width(b)) begin
                  n_fail++;
                  $display("FAIL R10 pulse width bit %0d actual=%0d expected=%0d",
                           b, run[b], hi_width(b));
               end
               run[b] = 0;
            end
         end
         // R9 R11: exact masking; feedback bit never masked
         if (exact_on) check("R9 R11 stop mask", a, e & ~{1'b0, mask_exp});
      end
   end

   task automatic send_bits(input logic [11:0] w, input int hi, input int lo);
      for (int i = hi; i >= lo; i--) begin
         stop_dat = w[i];
         #7 stop_clk = 1'b1;
         #7 stop_clk = 1'b0;
      end
   endtask

   localparam logic [11:0] STOP_WORD = 12'b1000_0001_0010; // q_c[3], q_b[0], q_a[1]

   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      // R8: outputs low from the start of reset
      repeat (2) @(negedge clk_src);
      check("R8 initial reset", act_vec(), 13'd0);

      // table of configurations: R1 R2 R3 R4 R5 R6 R7
      for (int v = 0; v < 8; v++) begin
         reset_with(VEC[v]);
         repeat (300) begin
            logic [12:0] e, a;
            @(negedge clk_src);
            e = expect_vec(k);
            a = act_vec();
            check(pre_div1 ? "R2 R6 bank A" : "R1 R2 bank A", {9'd0, a[3:0]}, {9'd0, e[3:0]});
            check("R3 R6 bank B", {9'd0, a[7:4]}, {9'd0, e[7:4]});
            check("R4 R6 bank C low", {11'd0, a[9:8]}, {11'd0, e[9:8]});
            check("R7 bank C upper", {11'd0, a[11:10]}, {11'd0, e[11:10]});
            check("R5 R6 feedback", {12'd0, a[12]}, {12'd0, e[12]});
         end
      end

      // R8: asynchronous reset in the middle of a run, then restart aligned
      reset_with(VEC[0]);
      repeat (7) @(negedge clk_src);
      rst = 1'b1;
      #1;
      check("R8 async clear", act_vec(), 13'd0);
      @(negedge clk_src);
      rst = 1'b0;
      repeat (40) begin
         @(negedge clk_src);
         check("R8 R6 restart", act_vec(), expect_vec(k));
      end

      // stop control: R9 R10 R11
      reset_with({1'b1, 2'd0, 2'd3, 2'd0, 3'd0, 1'b1});
      for (int b = 0; b < 13; b++) run[b] = 0;
      mon_on = 1; exact_on = 1; mask_exp = '0;
      send_bits(STOP_WORD, 11, 1);          // R9: eleven bits do nothing
      repeat (20) @(negedge clk_src);
      exact_on = 0;
      send_bits(STOP_WORD, 0, 0);
      repeat (30) @(negedge clk_src);
      mask_exp = STOP_WORD; exact_on = 1;
      repeat (120) @(negedge clk_src);
      exact_on = 0;
      send_bits(12'd0, 11, 0);              // release everything
      repeat (30) @(negedge clk_src);
      mask_exp = '0; exact_on = 1;
      repeat (120) @(negedge clk_src);
      mon_on = 0; exact_on = 0;

      finish_up();
   end
endmodule